// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block watches one receive stream and, when a frame ends, produces that frame's status flags. The flags are: alignment error, bad CRC, odd byte count, too long, too short, broadcast and multicast. A mode input picks the receive format. The first format carries four data bits per clock, qualified by a data-valid level. The second carries one bit per clock, qualified by a carrier-sense level. Both formats share the `rxValid` input.

An upstream delimiter detector pulses `frameStart` in the cycle that carries the last unit of the start-frame delimiter. From the next cycle on, the block counts received units (nibbles or bits) until `rxValid` drops. It never looks at the data itself. The CRC verdict comes from an external checker on `crcOk`, and the destination address comes in on `destAddr`. Both are sampled in the cycle in which `rxValid` is first seen low.

The flags are registered at that end-of-frame edge. A one-cycle `stsValid` pulse is raised in the same cycle. The flags then hold their values until the next `frameStart` clears them.

Top module: `rxStatusGen`

## Requirements
- R1: In nibble mode (`serialMode`=0), `alignErr` is 1 only when the frame's `badCrc` is 1 and the number of nibbles counted after the delimiter is odd.
- R2: In serial mode (`serialMode`=1), `alignErr` is 1 only when the frame's `badCrc` is 1 and the number of bits counted is not a multiple of 8.
- R3: `badCrc` is 1 when `crcOk` is 0 at end of frame, or when `rxErr` was high in the delimiter cycle or in any counted cycle of the frame.
- R4: `tooLong` is 1 when the byte count exceeds 1518. The byte count is the units counted divided by 2 in nibble mode, or divided by 8 in serial mode, rounded down.
- R5: `tooShort` is 1 when the byte count is below 64.
- R6: `oddFrame` is 1 when the byte count is odd.
- R7: `bcast` is 1 when all 48 bits of `destAddr` are ones.
- R8: `mcast` is 1 when `destAddr[40]` (the group bit of the first address byte, which is `destAddr[47:40]`) is 1 and the address is not broadcast.
- R9: `stsValid` is high for exactly one cycle. It is visible in the cycle after the clock edge that samples `rxValid` low for the first time in a frame, and the flags are valid in that same cycle.
- R10: The clock edge that samples `frameStart` high clears all seven flags.
- R11: The unit counter holds at 16383 instead of wrapping. A very long frame therefore still reports `tooLong`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | 0 = nibble format, 1 = serial bit format |
| rxValid | input | 1 | Data valid (nibble) or carrier sense (serial) |
| rxErr | input | 1 | Receive error indication |
| frameStart | input | 1 | Pulse in the last delimiter cycle |
| crcOk | input | 1 | CRC checker verdict, sampled at end of frame |
| destAddr | input | 48 | Destination address, first byte in [47:40] |
| stsValid | output | 1 | One-cycle status strobe |
| alignErr | output | 1 | Alignment error |
| badCrc | output | 1 | CRC or receive error |
| oddFrame | output | 1 | Odd byte count |
| tooLong | output | 1 | Over maximum length |
| tooShort | output | 1 | Under minimum length |
| bcast | output | 1 | Broadcast destination |
| mcast | output | 1 | Multicast destination |

## Verification
The driver drops `rxValid` at a falling edge and records the due cycle as the current cycle plus one. The flags and `stsValid` come from a single register stage, so they must be visible at the falling edge that follows the next rising edge. The monitor pops an expected item only when it sees `stsValid`, and it compares the cycle number against the due cycle. This catches both a late strobe and an early one. The clearing of flags on `frameStart` has no strobe. The driver therefore samples the flags at the falling edge right after the edge that took `frameStart`, which is the first point at which the clear can be seen.

// File: rtl/rxStatusPkg.sv
package rxStatusPkg;
  typedef struct packed {
    logic clear;    // frame start: reset counter and flags
    logic countEn;  // one unit received
    logic capture;  // end of frame: latch flags
  } ctlStrobes_t;
endpackage

// File: rtl/rxStatusCtl.sv
module rxStatusCtl
  import rxStatusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        frameStart,
  output ctlStrobes_t strb,
  output logic        stsValid
);
  logic active;

  always_comb begin
    strb.clear   = frameStart;
    strb.countEn = active && rxValid && !frameStart;
    strb.capture = active && !rxValid && !frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      stsValid <= 1'b0;
    end else begin
      if (frameStart) active <= 1'b1;
      else if (active && !rxValid) active <= 1'b0;
      stsValid <= strb.capture;
    end
  end

  // R9: strobe lasts one cycle
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    stsValid |=> !stsValid);
  // R9: strobe follows an active frame whose valid level dropped
  assert_valid_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !rxValid && !frameStart) |=> stsValid);
endmodule

// File: rtl/rxStatusDp.sv
module rxStatusDp
  import rxStatusPkg::*;
#(
  parameter int MAX_BYTES = 1518,
  parameter int MIN_BYTES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic        serialMode,
  input  logic        rxErr,
  input  logic        crcOk,
  input  logic [47:0] destAddr,
  output logic        alignErr,
  output logic        badCrc,
  output logic        oddFrame,
  output logic        tooLong,
  output logic        tooShort,
  output logic        bcast,
  output logic        mcast
);
  localparam int CNT_W = $clog2(MAX_BYTES * 8 + 16);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_BYTES);

  logic [CNT_W-1:0] unitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             errSeen;
  logic             crcBadNow;
  logic             partialOctet;
  logic             isBcast;

  always_comb begin
    byteCnt      = serialMode ? (unitCnt >> 3) : (unitCnt >> 1);
    partialOctet = serialMode ? (unitCnt[2:0] != 3'd0) : unitCnt[0];
    crcBadNow    = !crcOk || errSeen;
    isBcast      = &destAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCnt <= '0;
      errSeen <= 1'b0;
      {alignErr, badCrc, oddFrame, tooLong, tooShort, bcast, mcast} <= '0;
    end else if (strb.clear) begin
      unitCnt <= '0;
      errSeen <= rxErr;
      {alignErr, badCrc, oddFrame, tooLong, tooShort, bcast, mcast} <= '0;
    end else begin
      if (strb.countEn) begin
        if (unitCnt != CNT_MAX) unitCnt <= unitCnt + 1'b1;
        if (rxErr) errSeen <= 1'b1;
      end
      if (strb.capture) begin
        badCrc   <= crcBadNow;
        alignErr <= crcBadNow && partialOctet;
        oddFrame <= byteCnt[0];
        tooLong  <= byteCnt > MAX_L;
        tooShort <= byteCnt < MIN_L;
        bcast    <= isBcast;
        mcast    <= destAddr[40] && !isBcast;
      end
    end
  end

  // R1 R2: alignment error never without CRC failure
  assert_align_needs_crc_R1: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> badCrc);
  // R4 R5: length flags exclusive
  assert_len_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(tooLong && tooShort));
  // R8: multicast and broadcast exclusive
  assert_class_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(bcast && mcast));
  // R11: counter never goes backwards while counting
  assert_cnt_monotonic_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.clear) |=> unitCnt >= $past(unitCnt));
  // R10: flags cleared after frame start
  assert_clear_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !(alignErr || badCrc || oddFrame || tooLong || tooShort || bcast || mcast));
endmodule

// File: rtl/rxStatusGen.sv
module rxStatusGen
  import rxStatusPkg::*;
#(
  parameter int MAX_BYTES = 1518,
  parameter int MIN_BYTES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serialMode,
  input  logic        rxValid,
  input  logic        rxErr,
  input  logic        frameStart,
  input  logic        crcOk,
  input  logic [47:0] destAddr,
  output logic        stsValid,
  output logic        alignErr,
  output logic        badCrc,
  output logic        oddFrame,
  output logic        tooLong,
  output logic        tooShort,
  output logic        bcast,
  output logic        mcast
);
  ctlStrobes_t strb;

  rxStatusCtl u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .frameStart(frameStart),
    .strb(strb), .stsValid(stsValid)
  );

  rxStatusDp #(.MAX_BYTES(MAX_BYTES), .MIN_BYTES(MIN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .serialMode(serialMode),
    .rxErr(rxErr), .crcOk(crcOk), .destAddr(destAddr),
    .alignErr(alignErr), .badCrc(badCrc), .oddFrame(oddFrame),
    .tooLong(tooLong), .tooShort(tooShort), .bcast(bcast), .mcast(mcast)
  );
endmodule

// File: tb/rxStatusGen_tb.sv
module rxStatusGen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b0, rxValid = 1'b0, rxErr = 1'b0, frameStart = 1'b0, crcOk = 1'b1;
  logic [47:0] destAddr = '0;
  logic stsValid, alignErr, badCrc, oddFrame, tooLong, tooShort, bcast, mcast;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic prevValid = 1'b0;

  typedef struct {
    logic align, bcrc, odd, lng, shrt, bc, mc;
    int   due;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxStatusGen u_dut (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .rxValid(rxValid),
    .rxErr(rxErr), .frameStart(frameStart), .crcOk(crcOk), .destAddr(destAddr),
    .stsValid(stsValid), .alignErr(alignErr), .badCrc(badCrc), .oddFrame(oddFrame),
    .tooLong(tooLong), .tooShort(tooShort), .bcast(bcast), .mcast(mcast)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (stsValid && prevValid) chk(0, "R9 strobe width", 2, 1);
      if (stsValid) begin
        if (expQ.size() == 0) chk(0, "R9 unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          chk(cyc == e.due, "R9 strobe cycle", cyc, e.due);
          chk(alignErr == e.align, "R1/R2 alignErr", alignErr, e.align);
          chk(badCrc == e.bcrc, "R3 badCrc", badCrc, e.bcrc);
          chk(oddFrame == e.odd, "R6 oddFrame", oddFrame, e.odd);
          chk(tooLong == e.lng, "R4 tooLong", tooLong, e.lng);
          chk(tooShort == e.shrt, "R5 tooShort", tooShort, e.shrt);
          chk(bcast == e.bc, "R7 bcast", bcast, e.bc);
          chk(mcast == e.mc, "R8 mcast", mcast, e.mc);
        end
      end
      prevValid <= stsValid;
    end
  end

  // driver: one frame of n units after the delimiter
  task automatic runFrame(input bit ser, input int n, input int errAt,
                          input bit crc, input logic [47:0] addr);
    exp_t e;
    int units, bytes;
    bit anyErr, bcrc;
    serialMode = ser; crcOk = crc; destAddr = addr;
    frameStart = 1'b1; rxValid = 1'b1; rxErr = (errAt == -2);
    @(negedge clk);
    frameStart = 1'b0;
    chk(!(alignErr || badCrc || oddFrame || tooLong || tooShort || bcast || mcast),
        "R10 flags cleared", {alignErr, badCrc, oddFrame, tooLong, tooShort, bcast, mcast}, 0);
    for (int i = 0; i < n; i++) begin
      rxErr = (i == errAt);
      @(negedge clk);
    end
    rxValid = 1'b0; rxErr = 1'b0;
    units  = (n > 16383) ? 16383 : n;   // R11 saturation
    bytes  = ser ? units / 8 : units / 2;
    anyErr = (errAt >= 0 && errAt < n) || errAt == -2;
    bcrc   = !crc || anyErr;
    e.bcrc  = bcrc;
    e.align = bcrc && (ser ? (units % 8 != 0) : (units % 2 != 0));
    e.odd   = bytes % 2;
    e.lng   = bytes > 1518;
    e.shrt  = bytes < 64;
    e.bc    = &addr;
    e.mc    = addr[40] && !(&addr);
    e.due   = cyc + 1;
    expQ.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!stsValid && !alignErr && !badCrc && !oddFrame && !tooLong && !tooShort && !bcast && !mcast,
        "reset state", stsValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    runFrame(0, 128, -1, 1, 48'h0012_3456_789A);   // R5 boundary 64 bytes
    runFrame(0, 127, -1, 0, 48'h0012_3456_789A);   // R1 odd nibbles, bad CRC
    runFrame(0, 127, -1, 1, 48'h0012_3456_789A);   // R1 odd nibbles, good CRC
    runFrame(0, 3038, -1, 1, 48'hFFFF_FFFF_FFFF);  // R4 1519 bytes, R7
    runFrame(0, 3036, -1, 1, 48'h0100_5E00_0001);  // R4 1518 bytes, R8
    runFrame(1, 512, -1, 0, 48'h0300_0000_0000);   // R2 whole octets
    runFrame(1, 515, -1, 0, 48'h0012_3456_789A);   // R2 partial octet
    runFrame(1, 515, 100, 1, 48'h0012_3456_789A);  // R3 via rxErr
    runFrame(0, 200, 5, 1, 48'hFFFF_FFFF_FFFE);    // R3 rxErr, R7 near-broadcast
    runFrame(0, 200, -2, 1, 48'h0012_3456_789A);   // R3 rxErr in delimiter cycle
    runFrame(0, 10, -1, 1, 48'h0012_3456_789A);    // R5 runt
    runFrame(1, 20000, -1, 1, 48'h0012_3456_789A); // R11 saturation
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R9 missing strobes", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule